// File: doc/BRIEF.md
# Atomic Memory Operation Sequencer

This block carries out one atomic instruction at a time on behalf of a core: load-reserved, store-conditional, and the nine read-modify-write operations (swap, add, xor, and, or, signed and unsigned min and max). Each can be word or doubleword wide. A request brings the 5-bit function code, the 3-bit width code, the acquire and release bits, a byte address and the rs2 operand. The block turns the request into a read, a computation and a write on a simple memory port. It returns the value for the destination register with a one-cycle done pulse.

A single reservation, an address plus a valid bit, links a load-reserved to a later store-conditional. A snoop input lets stores from other sources break the reservation. Misaligned addresses and unknown codes end the request at once with an error flag and no memory traffic. Word data travels on the low 32 lanes of the data buses.

Top module: `amo_sequencer`

## Requirements
- R1: Function codes decode as follows: 00010 load-reserved, 00011 store-conditional, 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 min, 10100 max, 11000 unsigned min, 11100 unsigned max. Width code 010 means word (mem_size=0) and 011 means doubleword (mem_size=1).
- R2: Load-reserved reads memory once. At word width it returns the read word sign-extended to 64 bits; at doubleword width it returns the full value. It sets the reservation to its address.
- R3: Store-conditional succeeds only when the reservation is valid and holds exactly the request address. On success it writes rs2 (the low 32 bits at word width) and returns 0.
- R4: A failed store-conditional returns 1 and makes no memory access. Every store-conditional that is executed clears the reservation, whether it succeeds or fails.
- R5: A read-modify-write operation returns the original memory value (sign-extended at word width), not the computed value.
- R6: The value written is rs2 for swap and old op rs2 for the others. Min and max compare signed and the unsigned variants compare unsigned. At word width both the operation and the comparison use 32-bit operands.
- R7: A word write changes only the addressed 32-bit word. The value is on mem_wdata[31:0] and mem_wdata[63:32] is zero.
- R8: The read phase drives mem_aq=aq and mem_rl=aq&rl. The write phase drives mem_aq=aq&rl and mem_rl=rl.
- R9: A word address with addr[1:0]!=0, a doubleword address with addr[2:0]!=0, an unknown function code, or a width code other than 010/011 gives done with done_err=1, done_data=0 and no memory request.
- R10: A snoop whose address equals the reserved address clears the reservation. A snoop to any other address leaves it intact.
- R11: req_ready is low from acceptance until the done pulse. done lasts exactly one cycle. A memory request holds its address and direction until mem_ready.
- R12: After reset the block is ready, issues no memory request, has done low and holds no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_funct5 | input | 5 | Operation code |
| req_funct3 | input | 3 | Width code |
| req_aq | input | 1 | Acquire bit |
| req_rl | input | 1 | Release bit |
| req_addr | input | AW | Byte address |
| req_rs2 | input | 64 | Source operand |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 0 = word, 1 = doubleword |
| mem_aq | output | 1 | Acquire ordering on this access |
| mem_rl | output | 1 | Release ordering on this access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory took the request |
| mem_rvalid | input | 1 | Read data or write acknowledge |
| mem_rdata | input | 64 | Read data |
| snoop_valid | input | 1 | Another source stored to snoop_addr |
| snoop_addr | input | AW | Address of that store |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 64 | Destination-register value |
| done_err | output | 1 | Request rejected |

## Verification
The bench sweeps every read-modify-write operation at both widths over operand pairs chosen to split signed from unsigned order. A design that compared min/max with the wrong signedness, used 64-bit compares on word data, or returned the new value instead of the old one would show a wrong return or a wrong memory image. Reservation sequences cover a store-conditional with no reservation, with a mismatched address, a repeated one, and one after a matching or a non-matching snoop. A design that kept the reservation alive, or wrote memory on failure, would show a wrong status or an extra write. All misaligned offsets and all unknown function codes are swept. Any memory access or a missing error flag on those requests is reported, as are wrong aq/rl strobes on either phase.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [4:0] {
    FN_ADD  = 5'b00000,
    FN_SWAP = 5'b00001,
    FN_LR   = 5'b00010,
    FN_SC   = 5'b00011,
    FN_XOR  = 5'b00100,
    FN_OR   = 5'b01000,
    FN_AND  = 5'b01100,
    FN_MIN  = 5'b10000,
    FN_MAX  = 5'b10100,
    FN_MINU = 5'b11000,
    FN_MAXU = 5'b11100
  } amo_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_COMPUTE,
    ST_WRITE,
    ST_WAIT_WR,
    ST_DONE
  } seq_state_e;

  localparam logic [2:0] WID_WORD  = 3'b010;
  localparam logic [2:0] WID_DWORD = 3'b011;

  function automatic logic fn_known(input logic [4:0] f);
    case (f)
      FN_ADD, FN_SWAP, FN_LR, FN_SC, FN_XOR, FN_OR, FN_AND,
      FN_MIN, FN_MAX, FN_MINU, FN_MAXU: fn_known = 1'b1;
      default:                          fn_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [4:0]      fn_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] new_o
);
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] opb;
  logic            less_s;
  logic            less_u;

  // Word operands arrive sign-extended; the order of sign-extended
  // values matches 32-bit order both signed and unsigned.
  always_comb begin
    opb    = word_i ? {{HW{rs2_i[HW-1]}}, rs2_i[HW-1:0]} : rs2_i;
    less_s = $signed(old_i) < $signed(opb);
    less_u = old_i < opb;
    case (fn_i)
      FN_SWAP: new_o = opb;
      FN_ADD:  new_o = old_i + opb;
      FN_XOR:  new_o = old_i ^ opb;
      FN_AND:  new_o = old_i & opb;
      FN_OR:   new_o = old_i | opb;
      FN_MIN:  new_o = less_s ? old_i : opb;
      FN_MAX:  new_o = less_s ? opb : old_i;
      FN_MINU: new_o = less_u ? old_i : opb;
      FN_MAXU: new_o = less_u ? opb : old_i;
      default: new_o = opb;
    endcase
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_i,
  input  logic          snp_vld_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic [AW-1:0] chk_addr_i,
  output logic          hit_o
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          snp_hit;
  logic          addr_en;

  assign snp_hit = snp_vld_i && valid_q && (snp_addr_i == addr_q);
  assign hit_o   = valid_q && (addr_q == chk_addr_i);

  // set wins over clear and snoop in the same cycle
  always_comb begin
    valid_d = valid_q;
    addr_en = 1'b0;
    addr_d  = set_addr_i;
    if (set_i) begin
      valid_d = 1'b1;
      addr_en = 1'b1;
    end else if (clr_i || snp_hit) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  AST_SNOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !set_i) |=> !valid_q); // R10
  AST_LR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (valid_q && addr_q == $past(set_addr_i))); // R2
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !valid_q); // R4

endmodule

// File: rtl/amo_sequencer.sv
module amo_sequencer
  import amo_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [4:0]    req_funct5,
  input  logic [2:0]    req_funct3,
  input  logic          req_aq,
  input  logic          req_rl,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_rs2,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic          mem_aq,
  output logic          mem_rl,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          done,
  output logic [63:0]   done_data,
  output logic          done_err
);
  localparam int XLEN = 64;
  localparam int HW   = XLEN / 2;

  seq_state_e      state_q, state_d;
  logic [4:0]      fn_q;
  logic            word_q, aq_q, rl_q;
  logic [AW-1:0]   addr_q;
  logic [XLEN-1:0] rs2_q, old_q, new_q, rslt_q;
  logic            err_q, sc_ok_q;

  logic            accept, dec_word, dec_bad, misal;
  logic            is_sc_req, is_sc_run;
  logic            resv_hit, resv_set, resv_clr;
  logic [XLEN-1:0] alu_new, ld_ext, wsrc;

  logic            ld_req, ld_old, ld_new, ld_done;
  logic [XLEN-1:0] rslt_d;
  logic            err_d, sc_ok_d;

  // ---------------- decode ----------------
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign dec_word  = (req_funct3 == WID_WORD);
  assign misal     = dec_word ? (req_addr[1:0] != 2'b00) : (req_addr[2:0] != 3'b000);
  assign dec_bad   = !fn_known(req_funct5) ||
                     !((req_funct3 == WID_WORD) || (req_funct3 == WID_DWORD)) || misal;
  assign is_sc_req = (req_funct5 == FN_SC);
  assign is_sc_run = (fn_q == FN_SC);

  assign ld_ext = word_q ? {{HW{mem_rdata[HW-1]}}, mem_rdata[HW-1:0]} : mem_rdata;

  // ---------------- reservation ----------------
  assign resv_set = (state_q == ST_WAIT_RD) && mem_rvalid && (fn_q == FN_LR);
  assign resv_clr = accept && !dec_bad && is_sc_req;

  amo_resv #(.AW(AW)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (resv_set),
    .set_addr_i (addr_q),
    .clr_i      (resv_clr),
    .snp_vld_i  (snoop_valid),
    .snp_addr_i (snoop_addr),
    .chk_addr_i (req_addr),
    .hit_o      (resv_hit)
  );

  // ---------------- compute ----------------
  amo_alu #(.XLEN(XLEN)) u_alu (
    .fn_i   (fn_q),
    .word_i (word_q),
    .old_i  (old_q),
    .rs2_i  (rs2_q),
    .new_o  (alu_new)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_old  = 1'b0;
    ld_new  = 1'b0;
    ld_done = 1'b0;
    rslt_d  = rslt_q;
    err_d   = err_q;
    sc_ok_d = sc_ok_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          ld_done = 1'b1;
          err_d   = 1'b0;
          sc_ok_d = 1'b0;
          rslt_d  = '0;
          if (dec_bad) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else if (is_sc_req) begin
            if (resv_hit) begin
              sc_ok_d = 1'b1;
              state_d = ST_WRITE;
            end else begin
              rslt_d  = {{(XLEN-1){1'b0}}, 1'b1};
              state_d = ST_DONE;
            end
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ:    if (mem_ready) state_d = ST_WAIT_RD;
      ST_WAIT_RD: begin
        if (mem_rvalid) begin
          ld_old  = 1'b1;
          ld_done = 1'b1;
          rslt_d  = ld_ext;
          state_d = (fn_q == FN_LR) ? ST_DONE : ST_COMPUTE;
        end
      end
      ST_COMPUTE: begin
        ld_new  = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE:   if (mem_ready) state_d = ST_WAIT_WR;
      ST_WAIT_WR: if (mem_rvalid) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q   <= '0;
      word_q <= 1'b0;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      addr_q <= '0;
      rs2_q  <= '0;
    end else if (ld_req) begin
      fn_q   <= req_funct5;
      word_q <= dec_word;
      aq_q   <= req_aq;
      rl_q   <= req_rl;
      addr_q <= req_addr;
      rs2_q  <= req_rs2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (ld_old) old_q <= ld_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      new_q <= '0;
    else if (ld_new) new_q <= alu_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rslt_q  <= '0;
      err_q   <= 1'b0;
      sc_ok_q <= 1'b0;
    end else if (ld_done) begin
      rslt_q  <= rslt_d;
      err_q   <= err_d;
      sc_ok_q <= sc_ok_d;
    end
  end

  // ---------------- outputs ----------------
  assign wsrc = is_sc_run ? rs2_q : new_q;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_size  = !word_q;
    mem_addr  = addr_q;
    mem_wdata = word_q ? {{HW{1'b0}}, wsrc[HW-1:0]} : wsrc;
    mem_aq    = 1'b0;
    mem_rl    = 1'b0;
    if (state_q == ST_READ) begin
      mem_aq = aq_q;
      mem_rl = aq_q & rl_q;
    end else if (state_q == ST_WRITE) begin
      mem_aq = aq_q & rl_q;
      mem_rl = rl_q;
    end
    done      = (state_q == ST_DONE);
    done_data = rslt_q;
    done_err  = err_q;
  end

  // ---------------- assertions ----------------
  AST_SC_WRITE_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && is_sc_run) |-> sc_ok_q); // R3
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !req_ready) |-> !mem_req); // R9
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rl) |-> mem_aq); // R8
  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_aq) |-> mem_rl); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R11
  AST_WORD_WRITE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_size) |-> (mem_wdata[63:32] == 32'd0)); // R7

endmodule

// File: tb/sim_amo_sequencer.sv
`timescale 1ns/1ps
module sim_amo_sequencer;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [4:0]    req_funct5 = '0;
  logic [2:0]    req_funct3 = '0;
  logic          req_aq = 1'b0, req_rl = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_rs2 = '0;
  logic          mem_req, mem_we, mem_size, mem_aq, mem_rl;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_ready;
  logic          mem_rvalid;
  logic [63:0]   mem_rdata;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          done, done_err;
  logic [63:0]   done_data;

  amo_sequencer #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_funct5(req_funct5), .req_funct3(req_funct3),
    .req_aq(req_aq), .req_rl(req_rl), .req_addr(req_addr), .req_rs2(req_rs2),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_aq(mem_aq), .mem_rl(mem_rl), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .done(done), .done_data(done_data), .done_err(done_err)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [16];
  logic        ready_r = 1'b0, rvalid_r = 1'b0, pend = 1'b0, tog = 1'b0;
  logic [63:0] rdata_r = '0, pend_data = '0;
  logic        stall_en = 1'b0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic        rd_aq = 0, rd_rl = 0, wr_aq = 0, wr_rl = 0;
  logic [63:0] last_wdata = '0;
  logic        last_wsize = 0;

  assign mem_ready  = ready_r;
  assign mem_rvalid = rvalid_r;
  assign mem_rdata  = rdata_r;

  always @(negedge clk) begin
    rvalid_r = pend;
    if (pend) rdata_r = pend_data;
    pend = 1'b0;
    if (ready_r) begin
      ready_r = 1'b0;
    end else if (mem_req) begin
      if (!stall_en || tog) begin
        ready_r = 1'b1;
        pend    = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          wr_aq = mem_aq; wr_rl = mem_rl;
          last_wdata = mem_wdata; last_wsize = mem_size;
          if (mem_size) mem[mem_addr[6:3]] = mem_wdata;
          else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] = mem_wdata[31:0];
          else mem[mem_addr[6:3]][31:0] = mem_wdata[31:0];
          pend_data = '0;
        end else begin
          rd_cnt++;
          rd_aq = mem_aq; rd_rl = mem_rl;
          if (mem_size) pend_data = mem[mem_addr[6:3]];
          else pend_data = {32'd0, mem_addr[2] ? mem[mem_addr[6:3]][63:32]
                                               : mem[mem_addr[6:3]][31:0]};
        end
      end
      tog = !tog;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_fail = 0, pulse_bad = 0, busy_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] f, input logic [2:0] f3, input bit aq, input bit rl,
                        input logic [AW-1:0] a, input logic [63:0] s,
                        output logic [63:0] d, output bit e);
    int n;
    @(negedge clk);
    req_funct5 = f; req_funct3 = f3; req_aq = aq; req_rl = rl; req_addr = a; req_rs2 = s;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (req_ready) busy_bad++;
    n = 0;
    while (!done && n < 300) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      n++;
    end
    if (n >= 300) check(1'b0, "watchdog", 64'd0, 64'd1);
    d = done_data; e = done_err;
    @(negedge clk);
    if (done) pulse_bad++;
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] calc(input logic [4:0] f, input bit w,
                                       input logic [63:0] o, input logic [63:0] s);
    logic [31:0] a32, b32, r32;
    logic [63:0] r64;
    a32 = o[31:0]; b32 = s[31:0];
    case (f)
      5'b00001: begin r32 = b32;       r64 = s;       end
      5'b00000: begin r32 = a32 + b32; r64 = o + s;   end
      5'b00100: begin r32 = a32 ^ b32; r64 = o ^ s;   end
      5'b01100: begin r32 = a32 & b32; r64 = o & s;   end
      5'b01000: begin r32 = a32 | b32; r64 = o | s;   end
      5'b10000: begin r32 = ($signed(a32) < $signed(b32)) ? a32 : b32;
                      r64 = ($signed(o) < $signed(s)) ? o : s; end
      5'b10100: begin r32 = ($signed(a32) < $signed(b32)) ? b32 : a32;
                      r64 = ($signed(o) < $signed(s)) ? s : o; end
      5'b11000: begin r32 = (a32 < b32) ? a32 : b32; r64 = (o < s) ? o : s; end
      default:  begin r32 = (a32 < b32) ? b32 : a32; r64 = (o < s) ? s : o; end
    endcase
    return w ? {32'd0, r32} : r64;
  endfunction

  function automatic logic [63:0] pair_old(input int p);
    case (p)
      0: return 64'h0000_0000_0000_0007;
      1: return 64'hFFFF_FFFF_FFFF_FFF0;
      2: return 64'h1234_5678_8000_0000;
      default: return 64'h8000_0000_0000_0001;
    endcase
  endfunction

  function automatic logic [63:0] pair_rs2(input int p);
    case (p)
      0: return 64'h0000_0000_0000_0003;
      1: return 64'h0000_0000_0000_0010;
      2: return 64'hAAAA_AAAA_7FFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // ---------------- main sequence ----------------
  logic [63:0] d, exp_mem, other;
  bit          e;
  int          w0, r0;
  logic [4:0]  fns [9] = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                          5'b10000, 5'b10100, 5'b11000, 5'b11100};

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(req_ready && !mem_req && !done, "R12 reset outputs", {61'd0, req_ready, mem_req, done}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R4: store-conditional with no reservation after reset
    mem[8] = 64'h1111_2222_3333_4444;
    w0 = wr_cnt;
    run_op(5'b00011, 3'b011, 0, 0, 32'h40, 64'hDEAD, d, e);
    check(d == 64'd1 && !e, "R12 sc fails without reservation", d, 64'd1);
    check(wr_cnt == w0 && mem[8] == 64'h1111_2222_3333_4444, "R4 no write on sc fail", mem[8], 64'h1111_2222_3333_4444);

    // R2: load-reserved word, negative upper word
    mem[8] = 64'h8765_4321_0000_0005;
    run_op(5'b00010, 3'b010, 0, 0, 32'h44, 64'h0, d, e);
    check(d == 64'hFFFF_FFFF_8765_4321, "R2 lr word sign-extends", d, 64'hFFFF_FFFF_8765_4321);
    // R3: matching store-conditional succeeds, word-width narrow write
    run_op(5'b00011, 3'b010, 0, 0, 32'h44, 64'hFFFF_0000_CAFE_BABE, d, e);
    check(d == 64'd0, "R3 sc success returns 0", d, 64'd0);
    check(mem[8] == 64'hCAFE_BABE_0000_0005, "R3 R7 sc word writes addressed half", mem[8], 64'hCAFE_BABE_0000_0005);
    check(!last_wsize && last_wdata[63:32] == 32'd0, "R7 word wdata upper zero", last_wdata, {32'd0, last_wdata[31:0]});
    // R4: reservation consumed
    w0 = wr_cnt;
    run_op(5'b00011, 3'b010, 0, 0, 32'h44, 64'h1, d, e);
    check(d == 64'd1 && wr_cnt == w0, "R4 second sc fails", d, 64'd1);

    // R2 doubleword, R4 mismatch clears
    mem[9] = 64'h0123_4567_89AB_CDEF;
    run_op(5'b00010, 3'b011, 0, 0, 32'h48, 64'h0, d, e);
    check(d == 64'h0123_4567_89AB_CDEF, "R2 lr doubleword", d, 64'h0123_4567_89AB_CDEF);
    run_op(5'b00011, 3'b011, 0, 0, 32'h50, 64'h5, d, e);
    check(d == 64'd1, "R4 sc address mismatch fails", d, 64'd1);
    run_op(5'b00011, 3'b011, 0, 0, 32'h48, 64'h5, d, e);
    check(d == 64'd1 && mem[9] == 64'h0123_4567_89AB_CDEF, "R4 any sc clears reservation", d, 64'd1);

    // R10: snoop elsewhere keeps, snoop on match clears
    run_op(5'b00010, 3'b011, 0, 0, 32'h48, 64'h0, d, e);
    snoop(32'h60);
    run_op(5'b00011, 3'b011, 0, 0, 32'h48, 64'h7777, d, e);
    check(d == 64'd0 && mem[9] == 64'h7777, "R10 unrelated snoop ignored", d, 64'd0);
    run_op(5'b00010, 3'b011, 0, 0, 32'h48, 64'h0, d, e);
    snoop(32'h48);
    run_op(5'b00011, 3'b011, 0, 0, 32'h48, 64'h8888, d, e);
    check(d == 64'd1 && mem[9] == 64'h7777, "R10 matching snoop clears", d, 64'd1);

    // R1 R5 R6 R7: sweep ops x widths x operand pairs
    for (int k = 0; k < 9; k++) begin
      for (int p = 0; p < 4; p++) begin
        // doubleword at 0x28
        mem[5] = pair_old(p);
        exp_mem = calc(fns[k], 1'b0, pair_old(p), pair_rs2(p));
        run_op(fns[k], 3'b011, 0, 0, 32'h28, pair_rs2(p), d, e);
        check(d == pair_old(p) && !e, $sformatf("R5 dword ret fn=%b p=%0d", fns[k], p), d, pair_old(p));
        check(mem[5] == exp_mem, $sformatf("R6 dword new fn=%b p=%0d", fns[k], p), mem[5], exp_mem);
        // word at 0x20 (low half) or 0x24 (high half)
        other = 64'h5A5A_5A5A_5A5A_5A5A;
        if (p[0]) mem[4] = {pair_old(p)[31:0], other[31:0]};
        else      mem[4] = {other[63:32], pair_old(p)[31:0]};
        exp_mem = calc(fns[k], 1'b1, pair_old(p), pair_rs2(p));
        run_op(fns[k], 3'b010, 0, 0, p[0] ? 32'h24 : 32'h20, pair_rs2(p), d, e);
        check(d == sx32(pair_old(p)[31:0]), $sformatf("R5 word ret fn=%b p=%0d", fns[k], p), d, sx32(pair_old(p)[31:0]));
        if (p[0]) check(mem[4] == {exp_mem[31:0], other[31:0]}, $sformatf("R6 R7 word hi fn=%b p=%0d", fns[k], p),
                        mem[4], {exp_mem[31:0], other[31:0]});
        else      check(mem[4] == {other[63:32], exp_mem[31:0]}, $sformatf("R6 R7 word lo fn=%b p=%0d", fns[k], p),
                        mem[4], {other[63:32], exp_mem[31:0]});
      end
    end

    // R8: all aq/rl combinations on an add
    for (int q = 0; q < 4; q++) begin
      mem[6] = 64'd1;
      run_op(5'b00000, 3'b011, q[1], q[0], 32'h30, 64'd1, d, e);
      check({rd_aq, rd_rl} == {q[1], q[1] & q[0]}, $sformatf("R8 read strobes aqrl=%0d", q),
            {62'd0, rd_aq, rd_rl}, {62'd0, q[1], q[1] & q[0]});
      check({wr_aq, wr_rl} == {q[1] & q[0], q[0]}, $sformatf("R8 write strobes aqrl=%0d", q),
            {62'd0, wr_aq, wr_rl}, {62'd0, q[1] & q[0], q[0]});
    end

    // R9: misaligned offsets
    for (int o = 1; o < 8; o++) begin
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(5'b00000, 3'b011, 0, 0, 32'h30 + o, 64'd1, d, e);
      check(e && d == 0 && rd_cnt == r0 && wr_cnt == w0, $sformatf("R9 dword misaligned +%0d", o), {63'd0, e}, 64'd1);
    end
    for (int o = 1; o < 4; o++) begin
      r0 = rd_cnt;
      run_op(5'b00000, 3'b010, 0, 0, 32'h30 + o, 64'd1, d, e);
      check(e && rd_cnt == r0, $sformatf("R9 word misaligned +%0d", o), {63'd0, e}, 64'd1);
    end
    // R9: bad width codes
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3) continue;
      r0 = rd_cnt;
      run_op(5'b00000, c[2:0], 0, 0, 32'h30, 64'd1, d, e);
      check(e && rd_cnt == r0, $sformatf("R1 R9 width code %0d rejected", c), {63'd0, e}, 64'd1);
    end
    // R1 R9: unknown function codes
    for (int c = 0; c < 32; c++) begin
      if (c == 0 || c == 1 || c == 2 || c == 3 || c == 4 || c == 8 || c == 12 ||
          c == 16 || c == 20 || c == 24 || c == 28) continue;
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(c[4:0], 3'b011, 0, 0, 32'h30, 64'd1, d, e);
      check(e && rd_cnt == r0 && wr_cnt == w0, $sformatf("R1 R9 unknown code %0d", c), {63'd0, e}, 64'd1);
    end

    // R11: stalled memory handshake still gives correct result
    stall_en = 1'b1;
    mem[7] = 64'd100;
    run_op(5'b00000, 3'b011, 0, 0, 32'h38, 64'd23, d, e);
    check(d == 64'd100 && mem[7] == 64'd123, "R11 stalled handshake", mem[7], 64'd123);
    stall_en = 1'b0;

    check(pulse_bad == 0, "R11 done one cycle", pulse_bad, 0);
    check(busy_bad == 0, "R11 not ready while busy", busy_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule